// File: doc/BRIEF.md
# Store Completion Tracker

This block follows write instructions whose data has been split into several store sub-requests. It learns about each sub-request on a registration port, tagged with the sequence number of the owning instruction. It also hears a confirmation for each sub-request once that sub-request has reached its final destination. When every registered sub-request of an instruction has been confirmed, the block sends a single completion message back to the requester. That message is separate from, and later than, any acceptance-level acknowledgment given further up the pipe. The message carries the requester port identifier and the instruction tag, both captured from the instruction's first sub-request.

A small table of `ENTRIES` slots is searched by sequence number. A slot is claimed by the first sub-request of an instruction and holds a pending count of `CNT_W` bits. When its count drains to zero, the slot waits on a valid/ready completion port and is released on the handshake. Registrations are refused through `add_ready` when they cannot be taken. A confirmation that matches no instruction with a non-zero count is reported on a one-cycle error flag.

Top module: `stct_tracker`

## Requirements
- R1: After reset `done_valid` is 0, `ack_err` is 0 and `add_ready` is 1 for any sequence number.
- R2: The first accepted registration of a sequence number claims a free slot with a count of 1, and it records that registration's `add_port` and `add_tag`. Later registrations of the same number do not alter the recorded values.
- R3: Each further accepted registration of an instruction with a non-zero count adds 1 to its count. Each confirmation (`ack_valid`) of it subtracts 1. While the count is above zero no completion is offered for it.
- R4: The clock edge that takes the confirmation bringing a count to zero makes `done_valid` 1 right after that edge. The completion shows the recorded port and tag, and exactly one completion is offered per instruction.
- R5: A confirmation whose sequence number matches no slot, or matches a slot whose count is already zero, raises `ack_err` for exactly the cycle after it. It changes no count. A confirmation that matches raises no error.
- R6: A registration and a confirmation accepted in the same cycle for the same instruction leave its count unchanged and produce no completion.
- R7: While `done_valid` is 1 and `done_ready` is 0, the completion port keeps `done_valid`, `done_port` and `done_tag` unchanged. The slot is freed on the edge where both are 1, and `done_valid` drops then if no other slot is waiting.
- R8: `add_ready` is 0 in three cases: the sequence number is new and no slot is free; the matching count is at its maximum (all ones in `CNT_W` bits); or the sequence number matches a slot still waiting to deliver its completion.
- R9: When the completion port is not holding a stalled offer and several slots are waiting, the lowest-numbered slot is offered first. Slots are claimed lowest free index first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| add_valid | input | 1 | Registration of one store sub-request |
| add_ready | output | 1 | Registration can be taken this cycle |
| add_seq | input | SEQ_W | Sequence number of the registering instruction |
| add_port | input | PORT_W | Requester port identifier |
| add_tag | input | TAG_W | Instruction tag |
| ack_valid | input | 1 | Destination confirmation of one sub-request |
| ack_seq | input | SEQ_W | Sequence number of the confirmed instruction |
| ack_err | output | 1 | Confirmation of the previous cycle matched nothing pending |
| done_valid | output | 1 | Completion offered |
| done_ready | input | 1 | Requester takes the completion |
| done_port | output | PORT_W | Recorded requester port of the completed instruction |
| done_tag | output | TAG_W | Recorded tag of the completed instruction |

## Verification
`add_ready` is combinational on the current inputs and slot state, so the bench reads it one time step after driving a registration and before the clock edge. `done_valid`, `done_port` and `done_tag` change on the edge that takes the final confirmation or the handshake. `ack_err` is registered on the edge that takes the faulty confirmation. The bench therefore reads all three one time step after that edge. Every stimulus is applied just after a rising edge, so each result is read exactly one edge later, with no extra cycles of slack.

// File: rtl/stct_pkg.sv
package stct_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_UP   = 2'd1,
    CNT_DOWN = 2'd2
  } cnt_op_e;

  // A simultaneous increment and decrement cancel out.
  function automatic cnt_op_e count_op(input logic up, input logic down);
    if (up && !down)      return CNT_UP;
    else if (down && !up) return CNT_DOWN;
    else                  return CNT_HOLD;
  endfunction
endpackage

// File: rtl/stct_pick.sv
module stct_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  function automatic logic [N-1:0] lowest_set(input logic [N-1:0] v);
    return v & (~v + N'(1));
  endfunction

  assign gnt_o = lowest_set(req_i);
  assign any_o = |req_i;
endmodule

// File: rtl/stct_entry.sv
module stct_entry #(
  parameter int SEQ_W  = 8,
  parameter int PORT_W = 4,
  parameter int TAG_W  = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic              inc_i,
  input  logic              dec_i,
  input  logic              release_i,
  input  logic [SEQ_W-1:0]  seq_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic              busy_o,
  output logic              drain_o,
  output logic              full_o,
  output logic [SEQ_W-1:0]  seq_o,
  output logic [PORT_W-1:0] port_o,
  output logic [TAG_W-1:0]  tag_o
);
  import stct_pkg::*;

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c,
                                                  input cnt_op_e op);
    case (op)
      CNT_UP:   return c + CNT_ONE;
      CNT_DOWN: return c - CNT_ONE;
      default:  return c;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      seq_o  <= '0;
      port_o <= '0;
      tag_o  <= '0;
    end else if (alloc_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_ONE;
      seq_o  <= seq_i;
      port_o <= port_i;
      tag_o  <= tag_i;
    end else if (release_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q <= step_count(cnt_q, count_op(inc_i, dec_i));
    end
  end

  assign busy_o  = busy_q;
  assign drain_o = busy_q && (cnt_q == '0);
  assign full_o  = busy_q && (cnt_q == CNT_MAX);
endmodule

// File: rtl/stct_tracker.sv
module stct_tracker #(
  parameter int ENTRIES = 4,
  parameter int SEQ_W   = 8,
  parameter int PORT_W  = 4,
  parameter int TAG_W   = 8,
  parameter int CNT_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              add_valid,
  output logic              add_ready,
  input  logic [SEQ_W-1:0]  add_seq,
  input  logic [PORT_W-1:0] add_port,
  input  logic [TAG_W-1:0]  add_tag,
  input  logic              ack_valid,
  input  logic [SEQ_W-1:0]  ack_seq,
  output logic              ack_err,
  output logic              done_valid,
  input  logic              done_ready,
  output logic [PORT_W-1:0] done_port,
  output logic [TAG_W-1:0]  done_tag
);
  logic [ENTRIES-1:0] busy, drain, full;
  logic [ENTRIES-1:0] add_hit, add_wait, ack_hit, free_slot;
  logic [ENTRIES-1:0] alloc_gnt, pick_gnt, sel, lock_q;
  logic [ENTRIES-1:0] inc_vec, dec_vec, alloc_vec, rel_vec;
  logic               any_free, any_drain, any_add_hit, add_fire, ack_err_q;
  logic [SEQ_W-1:0]   seq_q  [ENTRIES];
  logic [PORT_W-1:0]  port_q [ENTRIES];
  logic [TAG_W-1:0]   tag_q  [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    stct_entry #(
      .SEQ_W(SEQ_W), .PORT_W(PORT_W), .TAG_W(TAG_W), .CNT_W(CNT_W)
    ) u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_i   (alloc_vec[g]),
      .inc_i     (inc_vec[g]),
      .dec_i     (dec_vec[g]),
      .release_i (rel_vec[g]),
      .seq_i     (add_seq),
      .port_i    (add_port),
      .tag_i     (add_tag),
      .busy_o    (busy[g]),
      .drain_o   (drain[g]),
      .full_o    (full[g]),
      .seq_o     (seq_q[g]),
      .port_o    (port_q[g]),
      .tag_o     (tag_q[g])
    );
    assign add_hit[g]   = busy[g] && !drain[g] && (seq_q[g] == add_seq);
    assign add_wait[g]  = drain[g] && (seq_q[g] == add_seq);
    assign ack_hit[g]   = busy[g] && !drain[g] && (seq_q[g] == ack_seq);
    assign free_slot[g] = !busy[g];
  end

  stct_pick #(.N(ENTRIES)) u_free_pick (
    .req_i (free_slot),
    .gnt_o (alloc_gnt),
    .any_o (any_free)
  );

  stct_pick #(.N(ENTRIES)) u_done_pick (
    .req_i (drain),
    .gnt_o (pick_gnt),
    .any_o (any_drain)
  );

  // Registration side
  assign any_add_hit = |add_hit;
  assign add_ready   = !(|add_wait) &&
                       (any_add_hit ? !(|(add_hit & full)) : any_free);
  assign add_fire    = add_valid && add_ready;
  assign inc_vec     = {ENTRIES{add_fire}} & add_hit;
  assign alloc_vec   = {ENTRIES{add_fire && !any_add_hit}} & alloc_gnt;

  // Confirmation side
  assign dec_vec = {ENTRIES{ack_valid}} & ack_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_err_q <= 1'b0;
    else        ack_err_q <= ack_valid && !(|ack_hit);
  end
  assign ack_err = ack_err_q;

  // Completion side: a stalled offer is locked until taken
  assign sel        = (|lock_q) ? lock_q : (any_drain ? pick_gnt : '0);
  assign done_valid = |sel;
  assign rel_vec    = sel & {ENTRIES{done_ready}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         lock_q <= '0;
    else if (done_valid && !done_ready) lock_q <= sel;
    else                                lock_q <= '0;
  end

  always_comb begin
    done_port = '0;
    done_tag  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (sel[i]) begin
        done_port = done_port | port_q[i];
        done_tag  = done_tag | tag_q[i];
      end
    end
  end
endmodule

// File: rtl/stct_checker.sv
module stct_checker #(
  parameter int ENTRIES = 4,
  parameter int PORT_W  = 4,
  parameter int TAG_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ack_valid,
  input logic               ack_err,
  input logic               done_valid,
  input logic               done_ready,
  input logic [PORT_W-1:0]  done_port,
  input logic [TAG_W-1:0]   done_tag,
  input logic [ENTRIES-1:0] add_hit,
  input logic [ENTRIES-1:0] ack_hit,
  input logic [ENTRIES-1:0] rel_vec
);
  // R7: stalled completion stays put
  a_r7_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !done_ready |=> done_valid && $stable(done_port) && $stable(done_tag));

  // R7: at most one slot freed per handshake
  a_r7_single_release: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rel_vec));

  // R2: a sequence number occupies at most one live slot
  a_r2_unique_seq: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(add_hit));

  // R5: unmatched confirmation flagged next cycle
  a_r5_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && (ack_hit == '0) |=> ack_err);

  // R5: matched confirmation not flagged
  a_r5_no_false_err: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && (ack_hit != '0) |=> !ack_err);
endmodule

bind stct_tracker stct_checker #(
  .ENTRIES(ENTRIES), .PORT_W(PORT_W), .TAG_W(TAG_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ack_valid  (ack_valid),
  .ack_err    (ack_err),
  .done_valid (done_valid),
  .done_ready (done_ready),
  .done_port  (done_port),
  .done_tag   (done_tag),
  .add_hit    (add_hit),
  .ack_hit    (ack_hit),
  .rel_vec    (rel_vec)
);

// File: tb/stct_tracker_bench.sv
module stct_tracker_bench;
  localparam int ENTRIES = 4;
  localparam int SEQ_W   = 8;
  localparam int PORT_W  = 4;
  localparam int TAG_W   = 8;
  localparam int CNT_W   = 3;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              add_valid = 1'b0;
  logic              add_ready;
  logic [SEQ_W-1:0]  add_seq = '0;
  logic [PORT_W-1:0] add_port = '0;
  logic [TAG_W-1:0]  add_tag = '0;
  logic              ack_valid = 1'b0;
  logic [SEQ_W-1:0]  ack_seq = '0;
  logic              ack_err;
  logic              done_valid;
  logic              done_ready = 1'b0;
  logic [PORT_W-1:0] done_port;
  logic [TAG_W-1:0]  done_tag;

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  stct_tracker #(
    .ENTRIES(ENTRIES), .SEQ_W(SEQ_W), .PORT_W(PORT_W), .TAG_W(TAG_W), .CNT_W(CNT_W)
  ) u_stct_tracker (
    .clk(clk), .rst_n(rst_n),
    .add_valid(add_valid), .add_ready(add_ready), .add_seq(add_seq),
    .add_port(add_port), .add_tag(add_tag),
    .ack_valid(ack_valid), .ack_seq(ack_seq), .ack_err(ack_err),
    .done_valid(done_valid), .done_ready(done_ready),
    .done_port(done_port), .done_tag(done_tag)
  );

  function automatic logic [PORT_W-1:0] port_of(input int s);
    return PORT_W'(s % 16);
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input int s);
    return TAG_W'((s * 7) ^ 8'h5A);
  endfunction

  task automatic chk(input bit ok, input string rid, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rid, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_add(input int s, input logic [PORT_W-1:0] p, input logic [TAG_W-1:0] t);
    add_valid = 1'b1; add_seq = SEQ_W'(s); add_port = p; add_tag = t;
    tick();
    add_valid = 1'b0;
  endtask

  task automatic do_ack(input int s);
    ack_valid = 1'b1; ack_seq = SEQ_W'(s);
    tick();
    ack_valid = 1'b0;
  endtask

  task automatic take_done();
    done_ready = 1'b1;
    tick();
    done_ready = 1'b0;
  endtask

  task automatic probe_ready(input int s, input bit exp, input string rid);
    add_seq = SEQ_W'(s);
    #1;
    chk(add_ready == exp, rid, int'(add_ready), int'(exp));
  endtask

  task automatic expect_done(input int s, input string rid);
    chk(done_valid == 1'b1, rid, int'(done_valid), 1);
    chk(done_port == port_of(s), rid, int'(done_port), int'(port_of(s)));
    chk(done_tag == tag_of(s), rid, int'(done_tag), int'(tag_of(s)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // R1: reset state
    chk(done_valid == 1'b0, "R1", int'(done_valid), 0);
    chk(ack_err == 1'b0, "R1", int'(ack_err), 0);
    probe_ready(77, 1'b1, "R1");

    // R5: confirmation for an unknown instruction
    do_ack(99);
    chk(ack_err == 1'b1, "R5", int'(ack_err), 1);
    tick();
    chk(ack_err == 1'b0, "R5", int'(ack_err), 0);

    // Sweep every pending depth 1..CNT_MAX
    for (int n = 1; n <= CNT_MAX; n++) begin
      int s;
      s = 30 + n;
      do_add(s, port_of(s), tag_of(s));
      for (int k = 2; k <= n; k++)
        do_add(s, port_of(s) ^ 4'hF, ~tag_of(s)); // R2: later identity ignored
      if (n == CNT_MAX) probe_ready(s, 1'b0, "R8");
      for (int k = 1; k <= n; k++) begin
        do_ack(s);
        chk(ack_err == 1'b0, "R5", int'(ack_err), 0);
        if (k < n) chk(done_valid == 1'b0, "R3", int'(done_valid), 0);
        else begin
          expect_done(s, "R4");
          expect_done(s, "R2");
        end
      end
      // R7: stall keeps the offer
      tick(); tick();
      expect_done(s, "R7");
      if (n == 1) begin
        probe_ready(s, 1'b0, "R8");
        do_ack(s); // count already zero
        chk(ack_err == 1'b1, "R5", int'(ack_err), 1);
        expect_done(s, "R5");
      end
      take_done();
      chk(done_valid == 1'b0, "R7", int'(done_valid), 0);
      tick();
      chk(done_valid == 1'b0, "R4", int'(done_valid), 0);
    end

    // R6: add and confirm in the same cycle
    do_add(50, port_of(50), tag_of(50));
    add_valid = 1'b1; add_seq = 8'd50; add_port = 4'h0; add_tag = 8'h00;
    ack_valid = 1'b1; ack_seq = 8'd50;
    tick();
    add_valid = 1'b0; ack_valid = 1'b0;
    chk(done_valid == 1'b0, "R6", int'(done_valid), 0);
    tick();
    chk(ack_err == 1'b0, "R6", int'(ack_err), 0);
    do_ack(50);
    expect_done(50, "R6");
    take_done();

    // R8 and R9: fill the table, then drain out of order
    for (int i = 0; i < ENTRIES; i++) do_add(20 + i, port_of(20 + i), tag_of(20 + i));
    probe_ready(24, 1'b0, "R8");
    probe_ready(21, 1'b1, "R8");
    do_ack(22);
    expect_done(22, "R9");
    do_ack(23);
    do_ack(21);
    expect_done(22, "R7");
    take_done();
    expect_done(21, "R9");
    take_done();
    expect_done(23, "R9");
    take_done();
    chk(done_valid == 1'b0, "R9", int'(done_valid), 0);
    do_ack(20);
    expect_done(20, "R9");
    take_done();
    chk(done_valid == 1'b0, "R7", int'(done_valid), 0);
    probe_ready(60, 1'b1, "R8");

    tick();
    finish_run();
  end
endmodule